// File: doc/BRIEF.md
# Receive Audio Sample FIFO

This block is a shallow FIFO that holds audio samples on their way from a digital audio receiver to a data register on the processor side. Each stored entry is a 24-bit sample and a channel tag that marks it as left or right. A set of static control inputs selects how the FIFO behaves. One input makes reads return zero. One turns the FIFO off so that it drops arriving samples. One is a soft reset that leaves a single zero sample pending. A two-bit field sets the fill level at which the full flag rises. The last enables channel realignment on reads.

The full flag is meant to serve as an interrupt or as a DMA receive request. A read is a one-cycle `rd_req` pulse, and the delivered sample appears on `rd_data` and `rd_right` one clock later. When realignment is enabled and the reader expects a left sample, a read discards any right-tagged entries at the head in the same cycle. This keeps left/right pairs in step.

Top module: `rx_audio_fifo`

## Requirements
- R1: After the asynchronous reset, `fill_level` is 0, `fifo_full` is 0, `overflow` is 0, and `rd_data` and `rd_right` are 0.
- R2: `fifo_full` is 1 exactly when `fill_level` is at least the threshold that `cfg_thresh` selects: code 0 gives 1, code 1 gives 2, code 2 gives 3 and code 3 gives 6. It follows the registered level, so a change in the level shows on the flag after the same clock edge.
- R3: A sample with `in_valid` high is stored when `cfg_rx_off` and `cfg_soft_rst` are low and there is room after the pops of the same cycle. A read and a write on a full FIFO in the same cycle both take effect.
- R4: A sample that is dropped for lack of room sets `overflow`. The flag stays set until the asynchronous reset or a soft reset clears it.
- R5: While `cfg_rx_off` is 1, `in_valid` has no effect: the level does not rise and `overflow` does not change.
- R6: A read with `cfg_read_zero` set to 1 makes `rd_data` and `rd_right` 0 on the next clock and removes no entry.
- R7: A normal read puts the head sample and its tag (1 = right) on `rd_data` and `rd_right` on the next clock and lowers the level by one. A read of an empty FIFO returns 0.
- R8: With `cfg_autosync` set to 1, a read made while a left sample is expected first discards the leading right-tagged entries and then delivers the first left entry. If no left entry is stored, all entries are discarded and 0 is returned. A left sample is expected after reset, after a soft reset, and after any delivered right sample.
- R9: While `cfg_soft_rst` is 1, the FIFO holds exactly one entry, a zero sample tagged left, and `overflow` is 0. Writes and reads are ignored, and a read during this time returns 0.
- R10: Samples leave in the order they arrived.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| cfg_read_zero | input | 1 | 1: reads return zero and do not pop |
| cfg_rx_off | input | 1 | 1: arriving samples are dropped silently |
| cfg_soft_rst | input | 1 | 1: hold the FIFO at one zero left sample |
| cfg_thresh | input | 2 | Full threshold select (1, 2, 3, 6) |
| cfg_autosync | input | 1 | 1: realign to a left sample on reads |
| in_valid | input | 1 | Sample strobe from the receiver |
| in_data | input | 24 | Arriving sample |
| in_right | input | 1 | Tag of the arriving sample, 1 = right |
| rd_req | input | 1 | Read pulse from the data register side |
| rd_data | output | 24 | Sample delivered by the last read |
| rd_right | output | 1 | Tag of the delivered sample |
| fifo_full | output | 1 | Threshold reached; DMA receive request |
| overflow | output | 1 | Sticky flag for a dropped write |
| fill_level | output | 4 | Entries stored |

## Verification
A write and a pop can fall in the same cycle. The case that matters is a write arriving at a full FIFO while a read, possibly one that skips several entries, frees room. The bench fills the FIFO to eight entries and then issues a write together with a read. It expects the write to be kept with no overflow, and a write without a read to be dropped with the overflow flag set. Random traffic keeps producing such collisions, including collisions with soft reset, which must win over both the write and the read. A reference queue in the bench judges each cycle's level, flags and read data.

// File: rtl/rx_audio_fifo.sv
module rx_audio_fifo #(
  parameter int DEPTH = 8,
  parameter int DW    = 24
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          cfg_read_zero,
  input  logic          cfg_rx_off,
  input  logic          cfg_soft_rst,
  input  logic [1:0]    cfg_thresh,
  input  logic          cfg_autosync,
  input  logic          in_valid,
  input  logic [DW-1:0] in_data,
  input  logic          in_right,
  input  logic          rd_req,
  output logic [DW-1:0] rd_data,
  output logic          rd_right,
  output logic          fifo_full,
  output logic          overflow,
  output logic [$clog2(DEPTH):0] fill_level
);
  localparam int AW = $clog2(DEPTH);
  localparam int CW = AW + 1;

  logic [DW-1:0]    dmem [DEPTH];
  logic [DEPTH-1:0] tag_q;
  logic [AW-1:0]    rd_ptr, wr_ptr, idx, hd_idx;
  logic [CW-1:0]    count, thr, skip, pop_n;
  logic             exp_left, ovf_q, found, do_read, deliver, wr_ok, drop;

  always_comb begin
    case (cfg_thresh)
      2'd0:    thr = CW'(1);
      2'd1:    thr = CW'(2);
      2'd2:    thr = CW'(3);
      default: thr = CW'(6);
    endcase
  end

  assign fifo_full  = count >= thr;
  assign overflow   = ovf_q;
  assign fill_level = count;

  always_comb begin
    skip  = '0;
    found = 1'b0;
    idx   = rd_ptr;
    for (int i = 0; i < DEPTH; i++) begin
      idx = rd_ptr + AW'(i);
      if (!found && CW'(i) < count) begin
        if (tag_q[idx]) skip = skip + 1'b1;
        else            found = 1'b1;
      end
    end
    if (!(cfg_autosync && exp_left)) begin
      skip  = '0;
      found = count != '0;
    end
    do_read = rd_req && !cfg_read_zero && !cfg_soft_rst;
    deliver = do_read && found;
    pop_n   = do_read ? skip + CW'(deliver) : '0;
    hd_idx  = rd_ptr + skip[AW-1:0];
    wr_ok   = in_valid && !cfg_rx_off && !cfg_soft_rst && ((count - pop_n) < CW'(DEPTH));
    drop    = in_valid && !cfg_rx_off && !cfg_soft_rst && !wr_ok;
  end

  always_ff @(posedge clk) begin
    if (cfg_soft_rst) begin
      dmem[0]  <= '0;
      tag_q[0] <= 1'b0;
    end else if (wr_ok) begin
      dmem[wr_ptr]  <= in_data;
      tag_q[wr_ptr] <= in_right;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rd_ptr   <= '0;
      wr_ptr   <= '0;
      count    <= '0;
      exp_left <= 1'b1;
      ovf_q    <= 1'b0;
      rd_data  <= '0;
      rd_right <= 1'b0;
    end else if (cfg_soft_rst) begin
      rd_ptr   <= '0;
      wr_ptr   <= AW'(1);
      count    <= CW'(1);
      exp_left <= 1'b1;
      ovf_q    <= 1'b0;
      if (rd_req) begin
        rd_data  <= '0;
        rd_right <= 1'b0;
      end
    end else begin
      rd_ptr <= rd_ptr + pop_n[AW-1:0];
      if (wr_ok) wr_ptr <= wr_ptr + 1'b1;
      count <= count - pop_n + CW'(wr_ok);
      if (drop) ovf_q <= 1'b1;
      if (rd_req) begin
        rd_data  <= deliver ? dmem[hd_idx] : '0;
        rd_right <= deliver & tag_q[hd_idx];
      end
      if (deliver) exp_left <= tag_q[hd_idx];
    end
  end
endmodule

module rx_audio_fifo_chk #(
  parameter int DEPTH = 8,
  parameter int DW    = 24
) (
  input logic          clk,
  input logic          rst_n,
  input logic          cfg_read_zero,
  input logic          cfg_rx_off,
  input logic          cfg_soft_rst,
  input logic          in_valid,
  input logic          rd_req,
  input logic [DW-1:0] rd_data,
  input logic          rd_right,
  input logic          overflow,
  input logic [$clog2(DEPTH):0] fill_level
);
  a_r9_soft_rst_one: assert property (@(posedge clk) disable iff (!rst_n)
    cfg_soft_rst |=> (fill_level == 1 && !overflow));

  a_r3_level_bound: assert property (@(posedge clk) disable iff (!rst_n)
    fill_level <= DEPTH);

  a_r5_off_no_write: assert property (@(posedge clk) disable iff (!rst_n)
    (cfg_rx_off && !rd_req && !cfg_soft_rst) |=> $stable(fill_level));

  a_r6_read_zero: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_req && cfg_read_zero) |=> (rd_data == '0 && !rd_right));

  a_r6_no_pop: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_req && cfg_read_zero && !cfg_soft_rst) |=> fill_level >= $past(fill_level));

  a_r4_sticky: assert property (@(posedge clk) disable iff (!rst_n)
    (overflow && !cfg_soft_rst) |=> overflow);

  a_r4_drop_sets: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && fill_level == DEPTH && !rd_req && !cfg_rx_off && !cfg_soft_rst) |=> overflow);
endmodule

bind rx_audio_fifo rx_audio_fifo_chk #(.DEPTH(DEPTH), .DW(DW)) u_chk (.*);

// File: tb/rx_audio_fifo_tb.sv
module rx_audio_fifo_tb_top;
  localparam int CLK_PERIOD = 10;
  localparam int DEPTH = 8;

  logic clk = 1'b0, rst_n = 1'b0;
  logic cfg_read_zero = 0, cfg_rx_off = 0, cfg_soft_rst = 0, cfg_autosync = 0;
  logic [1:0] cfg_thresh = 0;
  logic in_valid = 0, in_right = 0, rd_req = 0;
  logic [23:0] in_data = 0;
  logic [23:0] rd_data;
  logic rd_right, fifo_full, overflow;
  logic [3:0] fill_level;

  int total = 0, bad = 0;
  bit done = 0;

  logic [24:0] mq[$];
  bit m_ovf = 0, m_exp_left = 1;
  logic [24:0] m_rd = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  rx_audio_fifo dut_i (.*);

  function automatic int thr_of(logic [1:0] c);
    case (c)
      2'd0: return 1;
      2'd1: return 2;
      2'd2: return 3;
      default: return 6;
    endcase
  endfunction

  task automatic check(string tag, logic [31:0] act, logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic model_edge();
    if (cfg_soft_rst) begin
      mq.delete();
      mq.push_back(25'd0);
      m_ovf = 0;
      m_exp_left = 1;
      if (rd_req) m_rd = 0;
      return;
    end
    if (rd_req) begin
      m_rd = 0;
      if (!cfg_read_zero) begin
        if (cfg_autosync && m_exp_left)
          while (mq.size() > 0 && mq[0][24]) void'(mq.pop_front());
        if (mq.size() > 0) begin
          m_rd = mq.pop_front();
          m_exp_left = m_rd[24];
        end
      end
    end
    if (in_valid && !cfg_rx_off) begin
      if (mq.size() < DEPTH) mq.push_back({in_right, in_data});
      else m_ovf = 1;
    end
  endtask

  task automatic step(bit v, logic [23:0] d, bit r, bit rd);
    string lt, rt;
    @(negedge clk);
    in_valid = v; in_data = d; in_right = r; rd_req = rd;
    lt = cfg_soft_rst ? "R9" : (cfg_rx_off ? "R5" : "R3");
    rt = cfg_soft_rst ? "R9" : (cfg_read_zero ? "R6" : (cfg_autosync ? "R8" : "R7_R10"));
    @(posedge clk);
    model_edge();
    #1;
    check({lt, " level"}, 32'(fill_level), 32'(mq.size()));
    check("R2 full", 32'(fifo_full), 32'(mq.size() >= thr_of(cfg_thresh)));
    check("R4 overflow", 32'(overflow), 32'(m_ovf));
    if (rd) check({rt, " read"}, {7'd0, rd_right, rd_data}, {7'd0, m_rd});
  endtask

  initial begin
    int cyc = 0;
    while (!done) begin
      @(posedge clk);
      cyc++;
      if (cyc > 150000) begin
        total++; bad++;
        $display("FAIL watchdog expired");
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
      end
    end
  end

  initial begin
    void'($urandom(32'd4711));
    repeat (3) @(negedge clk);
    rst_n = 1;
    #1;
    check("R1 level", 32'(fill_level), 0);
    check("R1 full", 32'(fifo_full), 0);
    check("R1 overflow", 32'(overflow), 0);
    check("R1 rd_data", {7'd0, rd_right, rd_data}, 0);

    // R2: each threshold code as level climbs
    for (int c = 0; c < 4; c++) begin
      cfg_thresh = 2'(c);
      step(0, 0, 0, 0);
    end
    for (int k = 0; k < 6; k++) begin
      cfg_thresh = 2'(k % 4);
      step(1, 24'(k + 'h100), k[0], 0);
    end
    cfg_thresh = 2'd3;
    step(1, 24'h106, 0, 0);
    step(1, 24'h107, 1, 0);
    // R4 drop at full, then R3 same-cycle write and read at full
    step(1, 24'hBAD, 0, 0);
    step(1, 24'h108, 0, 1);
    // R6 read-zero does not pop
    cfg_read_zero = 1;
    step(0, 0, 0, 1);
    cfg_read_zero = 0;
    // R5 off mode ignores writes
    step(0, 0, 0, 1);
    cfg_rx_off = 1;
    step(1, 24'hDEAD, 1, 0);
    cfg_rx_off = 0;
    // R7 / R10 drain in order, including empty read
    repeat (9) step(0, 0, 0, 1);
    // R9 soft reset
    cfg_soft_rst = 1;
    step(1, 24'h55, 1, 1);
    cfg_soft_rst = 0;
    // R8 realignment after a right sample
    cfg_autosync = 1;
    step(1, 24'hA1, 1, 1);
    step(1, 24'hA2, 1, 0);
    step(1, 24'hA3, 1, 0);
    step(1, 24'hA4, 0, 0);
    step(1, 24'hA5, 1, 1);
    step(0, 0, 0, 1);
    step(0, 0, 0, 1);
    step(1, 24'hB1, 1, 1);
    step(1, 24'hB2, 1, 1);
    step(0, 0, 0, 1);

    for (int n = 0; n < 4000; n++) begin
      if ($urandom_range(0, 15) == 0) begin
        cfg_read_zero = ($urandom_range(0, 9) == 0);
        cfg_rx_off    = ($urandom_range(0, 9) == 0);
        cfg_autosync  = $urandom_range(0, 1) == 1;
        cfg_thresh    = 2'($urandom_range(0, 3));
      end
      cfg_soft_rst = ($urandom_range(0, 63) == 0);
      step($urandom_range(0, 2) != 0, 24'($urandom), $urandom_range(0, 2) == 0,
           $urandom_range(0, 2) == 0);
    end

    done = 1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule